// File: doc/BRIEF.md
# Bitfield Merge, Extract and Insert Unit

This block is a 32-bit bitfield execution unit for a RISC integer datapath. Each issued operation carries a 2-bit opcode, a destination operand, a source operand and a third operand. That third operand is either a bit mask or a packed field descriptor. The unit computes the result combinationally and captures it in an output register, so each operation completes one cycle after it is issued. A new operation may be issued every cycle.

Four operations are provided:
- **Merge** chooses, bit by bit, between the destination and the source under control of the mask.
- **Unsigned extract** pulls a field out of the source and right-justifies it.
- **Signed extract** does the same and then copies the field's top bit into every bit above the field.
- **Insert** writes the low bits of the source into a field of the destination and leaves the destination's other bits intact.

For the three field operations, the descriptor is checked. An index above 31, or a high index below the low index, gives a zero result and an error flag for that operation.

Top module: `bitfield_unit`

## Requirements
- R1: With opcode 0 (merge), the result is `(rd_in & ~rm_or_descr) | (rs & rm_or_descr)` over all 32 bits, and `out_err` stays low whatever the operand values.
- R2: For opcodes 1 to 3, the field's high index is taken from `rm_or_descr[11:6]` and its low index from `rm_or_descr[5:0]`. Bits 31:12 of the descriptor have no effect on the result or the error flag.
- R3: With opcode 1 (unsigned extract), result bit i equals `rs[lo+i]` for i from 0 to hi-lo, and every result bit above hi-lo is zero.
- R4: With opcode 2 (signed extract), result bits 0 to hi-lo are as in R3, and every result bit above hi-lo equals `rs[hi]`.
- R5: With opcode 3 (insert), result bits lo to hi equal `rs[0]` to `rs[hi-lo]`, and every other result bit equals the same bit of `rd_in`.
- R6: For opcodes 1 to 3, if the high index is below the low index, the result is zero and `out_err` is high for that operation.
- R7: For opcodes 1 to 3, if bit 5 of either 6-bit index is set (an index above 31), the result is zero and `out_err` is high for that operation.
- R8: `result`, `out_valid` and `out_err` are registered. They show an operation one cycle after it is presented with `in_valid` high. When `in_valid` is low, `result` holds its previous value and `out_valid` and `out_err` are low on the next cycle.
- R9: While `rst_n` is sampled low, `result` clears to zero and `out_valid` and `out_err` clear to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 2 | 0 merge, 1 unsigned extract, 2 signed extract, 3 insert |
| rd_in | input | 32 | Destination operand (kept bits for merge and insert) |
| rs | input | 32 | Source operand |
| rm_or_descr | input | 32 | Merge mask, or field descriptor (high index [11:6], low index [5:0]) |
| out_valid | output | 1 | Result register holds a new operation |
| result | output | 32 | Registered result |
| out_err | output | 1 | Descriptor of the operation just completed was illegal |

## Verification
A wrong mask from the descriptor decoder shows at the ports on the very next cycle. Depending on the operation, it appears as stray set bits above an extracted field, a wrong sign fill, or destination bits corrupted outside an inserted field. Each field operation is therefore swept over all 1024 pairs of high and low index, with operand patterns that differ from one another in every bit position.

A mistake in the validity check or the capture enable shows on the same cycle. It appears either as a nonzero result alongside the error flag, or as a result that changes while no operation was issued. Directed checks cover illegal indices and idle cycles.

// File: rtl/bfu_pkg.sv
// Package: shared sizes and the operation encoding for the bitfield unit.
// Assumes a 32-bit datapath with 6-bit descriptor indices.
package bfu_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;

    typedef enum logic [1:0] {
        OP_MERGE = 2'd0,
        OP_EXTU  = 2'd1,
        OP_EXTS  = 2'd2,
        OP_INS   = 2'd3
    } bfu_op_e;
endpackage

// File: rtl/bfu_desc_decode.sv
// Module: bfu_desc_decode
// Turns a packed field descriptor into bit positions and masks.
// low_mask has hi-lo+1 ones starting at bit 0; field_mask is low_mask
// moved up to bit lo. err flags an index beyond the datapath or a
// reversed range. Assumes DATA_W is a power of two no larger than 2**IDX_W.
module bfu_desc_decode #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic [2*IDX_W-1:0] descr,
    output logic [POS_W-1:0]   hi,
    output logic [POS_W-1:0]   lo,
    output logic [POS_W-1:0]   span,
    output logic [DATA_W-1:0]  low_mask,
    output logic [DATA_W-1:0]  field_mask,
    output logic               err
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(DATA_W - 1);
    localparam logic [POS_W-1:0] TOP_POS = POS_W'(DATA_W - 1);

    logic [IDX_W-1:0] hi_raw;
    logic [IDX_W-1:0] lo_raw;

    // Split the descriptor and check both indices.
    always_comb begin
        hi_raw = descr[2*IDX_W-1:IDX_W];
        lo_raw = descr[IDX_W-1:0];
        err    = (hi_raw > MAX_IDX) || (lo_raw > MAX_IDX) || (hi_raw < lo_raw);
        hi     = hi_raw[POS_W-1:0];
        lo     = lo_raw[POS_W-1:0];
    end

    // Build the right-justified and the positioned field masks.
    always_comb begin
        span       = hi - lo;
        low_mask   = {DATA_W{1'b1}} >> (TOP_POS - span);
        field_mask = low_mask << lo;
    end
endmodule

// File: rtl/bfu_field_ops.sv
// Module: bfu_field_ops
// Combinational result for all four operations. It assumes the masks
// come from bfu_desc_decode; it does not look at descriptor legality.
module bfu_field_ops
    import bfu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  bfu_op_e           op,
    input  logic [DATA_W-1:0] rd_in,
    input  logic [DATA_W-1:0] rs,
    input  logic [DATA_W-1:0] merge_mask,
    input  logic [POS_W-1:0]  hi,
    input  logic [POS_W-1:0]  lo,
    input  logic [DATA_W-1:0] low_mask,
    input  logic [DATA_W-1:0] field_mask,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] shifted_down;
    logic [DATA_W-1:0] shifted_up;
    logic              sign_bit;

    // Align the source for extract (down) and insert (up).
    always_comb begin
        shifted_down = rs >> lo;
        shifted_up   = rs << lo;
        sign_bit     = rs[hi];
    end

    // Select the operation.
    always_comb begin
        unique case (op)
            OP_MERGE: res = (rd_in & ~merge_mask) | (rs & merge_mask);
            OP_EXTU:  res = shifted_down & low_mask;
            OP_EXTS:  res = (shifted_down & low_mask) | ({DATA_W{sign_bit}} & ~low_mask);
            OP_INS:   res = (rd_in & ~field_mask) | (shifted_up & field_mask);
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/bitfield_unit.sv
// Module: bitfield_unit (top)
// Single-cycle bitfield merge/extract/insert with a registered result.
// Assumes in_valid qualifies opcode and operands in the same cycle.
// Merge ignores the descriptor; the field operations zero the result and
// raise out_err when the descriptor is illegal.
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int DATA_W = bfu_pkg::DATA_W,
    parameter int IDX_W  = bfu_pkg::IDX_W,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        opcode,
    input  logic [DATA_W-1:0] rd_in,
    input  logic [DATA_W-1:0] rs,
    input  logic [DATA_W-1:0] rm_or_descr,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              out_err
);
    bfu_op_e           op;
    logic [POS_W-1:0]  dec_hi;
    logic [POS_W-1:0]  dec_lo;
    logic [POS_W-1:0]  dec_span;
    logic [DATA_W-1:0] dec_low_mask;
    logic [DATA_W-1:0] dec_field_mask;
    logic              dec_err;
    logic [DATA_W-1:0] ops_res;
    logic              err_now;
    logic [DATA_W-1:0] next_res;
    logic [POS_W:0]    field_len;

    assign op = bfu_op_e'(opcode);

    bfu_desc_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_decode (
        .descr      (rm_or_descr[2*IDX_W-1:0]),
        .hi         (dec_hi),
        .lo         (dec_lo),
        .span       (dec_span),
        .low_mask   (dec_low_mask),
        .field_mask (dec_field_mask),
        .err        (dec_err)
    );

    bfu_field_ops #(.DATA_W(DATA_W)) u_ops (
        .op         (op),
        .rd_in      (rd_in),
        .rs         (rs),
        .merge_mask (rm_or_descr),
        .hi         (dec_hi),
        .lo         (dec_lo),
        .low_mask   (dec_low_mask),
        .field_mask (dec_field_mask),
        .res        (ops_res)
    );

    // Gate the error to field operations and force a zero result on error.
    always_comb begin
        err_now   = (op != OP_MERGE) && dec_err;
        next_res  = err_now ? '0 : ops_res;
        field_len = {1'b0, dec_span} + 1'b1;
    end

    // Output register: capture on valid, pulse valid and error one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid && err_now;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end

    p_merge_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MERGE) |=>
            (((result ^ $past(rd_in)) & ~$past(rm_or_descr)) == '0) &&
            (((result ^ $past(rs)) & $past(rm_or_descr)) == '0) && !out_err);

    p_extu_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_EXTU && !dec_err) |=>
            ((result >> $past(field_len)) == '0));

    p_exts_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_EXTS && !dec_err) |=>
            (result[DATA_W-1] == $past(rs[dec_hi])));

    p_ins_keep_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_INS && !dec_err) |=>
            (((result ^ $past(rd_in)) & ~$past(dec_field_mask)) == '0));

    p_err_zero_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (result == '0) && out_valid);

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_err && $stable(result));
endmodule

// File: tb/bitfield_unit_tb.sv
// Bench: exhaustive descriptor sweep of every field operation plus directed
// merge, illegal-index, idle and reset checks. Expected values come from a
// bit-by-bit model of the requirements.
module bitfield_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  opcode = 2'd0;
    logic [31:0] rd_in = '0;
    logic [31:0] rs = '0;
    logic [31:0] rm_or_descr = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        out_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitfield_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .rd_in(rd_in), .rs(rs), .rm_or_descr(rm_or_descr),
        .out_valid(out_valid), .result(result), .out_err(out_err)
    );

    // Bit-level model of the requirements.
    function automatic void model(input int op, input logic [31:0] d, input logic [31:0] s,
                                  input logic [31:0] m, output logic [31:0] exp, output logic e);
        int hi = int'(m[11:6]);
        int lo = int'(m[5:0]);
        exp = '0;
        e   = 1'b0;
        if (op == 0) begin
            for (int i = 0; i < 32; i++) exp[i] = m[i] ? s[i] : d[i];
            return;
        end
        if (hi > 31 || lo > 31 || hi < lo) begin
            e = 1'b1;
            return;
        end
        for (int i = 0; i < 32; i++) begin
            if (op == 3) exp[i] = (i >= lo && i <= hi) ? s[i-lo] : d[i];
            else if (i <= hi - lo) exp[i] = s[lo+i];
            else exp[i] = (op == 2) ? s[hi] : 1'b0;
        end
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation at a falling edge and check it one cycle later.
    task automatic run_op(input string req, input int op, input logic [31:0] d,
                          input logic [31:0] s, input logic [31:0] m);
        logic [31:0] exp;
        logic        e;
        model(op, d, s, m, exp, e);
        in_valid    = 1'b1;
        opcode      = 2'(op);
        rd_in       = d;
        rs          = s;
        rm_or_descr = m;
        @(negedge clk);
        check({req, " result"}, result, exp);
        check({req, " valid/err"}, {31'd0, out_valid, out_err}, {31'd0, 1'b1, e});
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 result", result, '0);
        check("R9 valid/err", {30'd0, out_valid, out_err}, '0);
        rst_n = 1'b1;

        // R1: merge patterns, with descriptor-looking masks that must not flag
        run_op("R1", 0, 32'hFFFF_0000, 32'h1234_5678, 32'h0F0F_0F0F);
        run_op("R1", 0, 32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF);
        run_op("R1", 0, 32'hCAFE_F00D, 32'hFFFF_FFFF, 32'h0000_0000);
        run_op("R1", 0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0000_0FC1);
        for (int k = 0; k < 64; k++)
            run_op("R1", 0, 32'h1357_9BDF * k, ~(32'h2468_ACE0 * k), 32'h0101_0101 << (k % 8));

        // R3 R4 R5 R6 R2: full sweep of legal-width indices with noisy upper bits
        for (int op = 1; op < 4; op++) begin
            for (int hi = 0; hi < 32; hi++) begin
                for (int lo = 0; lo < 32; lo++) begin
                    logic [31:0] s = 32'h9E37_79B9 ^ (32'h0101_0101 * hi) ^ (32'h1000_0001 << lo);
                    logic [31:0] d = ~s ^ 32'h0F0F_3C3C;
                    logic [31:0] m = {20'h5A3C7 ^ 20'(hi * 7 + lo), 6'(hi), 6'(lo)};
                    string tag = (hi < lo) ? "R6" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
                    run_op(tag, op, d, s, m);
                    if (hi >= lo) run_op(tag, op, s, d, m);
                end
            end
        end

        // R2: only bits 11:0 of the descriptor matter
        run_op("R2", 1, 32'h0, 32'hF0F0_1234, {20'hFFFFF, 6'd15, 6'd4});
        run_op("R2", 1, 32'h0, 32'hF0F0_1234, {20'h00000, 6'd15, 6'd4});
        run_op("R2", 3, 32'h8765_4321, 32'h0000_00AB, {20'hABCDE, 6'd23, 6'd16});

        // R7: bit 5 of either index set
        for (int op = 1; op < 4; op++) begin
            run_op("R7", op, 32'hFFFF_FFFF, 32'hFFFF_FFFF, {20'h0, 6'd32, 6'd0});
            run_op("R7", op, 32'hFFFF_FFFF, 32'hFFFF_FFFF, {20'h0, 6'd63, 6'd33});
            run_op("R7", op, 32'hFFFF_FFFF, 32'hFFFF_FFFF, {20'h0, 6'd40, 6'd5});
        end

        // R8: idle cycles hold result and drop valid and error
        run_op("R8", 2, 32'h0, 32'h8000_0000, {20'h0, 6'd31, 6'd31});
        held        = result;
        in_valid    = 1'b0;
        opcode      = 2'd1;
        rs          = 32'h1234_5678;
        rm_or_descr = {20'h0, 6'd2, 6'd9};
        @(negedge clk);
        check("R8 hold result", result, held);
        check("R8 idle valid/err", {30'd0, out_valid, out_err}, '0);
        @(negedge clk);
        check("R8 hold result again", result, held);

        // R9: reset mid-stream clears everything
        run_op("R8", 0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 mid reset result", result, '0);
        check("R9 mid reset valid/err", {30'd0, out_valid, out_err}, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule